// File: doc/BRIEF.md
# Pipelined Bitonic Key Sorter

This block sorts a whole vector of N unsigned keys every clock cycle. The keys arrive side by side on one wide bus, qualified by a valid bit. After a fixed number of cycles the same keys leave on a second wide bus in ascending order, again qualified by a valid bit. Lane 0 occupies the least significant W bits of each bus. On the output bus, lane 0 holds the smallest key.

Internally the sort is a bitonic network. Merge blocks of growing size alternate between ascending and descending direction, so that each level hands the next one rising-then-falling groups that are twice as long. The last level is one ascending merge over all N lanes. Every comparator column is followed by its own register stage. A new vector can therefore enter on every cycle while older vectors move through the later columns. The block has no backpressure and carries no payload: it is meant to sit in a stream that already runs at one vector per cycle.

Top module: `bsort_pipe`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly log2(N)·(log2(N)+1)/2 clock cycles. This is 6 cycles for N=8.
- R2: Whenever `out_valid` is high, the output lanes are in non-decreasing order from lane 0 (bits W-1:0) up to lane N-1.
- R3: Whenever `out_valid` is high, the output keys are a permutation of the keys accepted on the matching input cycle. The multiset of keys is preserved.
- R4: Vectors presented on consecutive cycles leave on consecutive cycles, with no bubble inserted.
- R5: While `rst_n` is low, `out_valid` is low and `out_keys` is all zero on the cycle after each sampled reset edge.
- R6: A vector whose keys are all equal leaves unchanged. Equal keys are never exchanged.
- R7: Vectors that are already ascending, and vectors that are strictly descending, both leave in ascending order.
- R8: Keys presented while `in_valid` is low have no effect. They never produce a high `out_valid`, and idle gaps in the input appear as equally long gaps in the output.
- R9: The extreme key values 0 and 2^W-1 sort correctly in any mixture. This includes every vector built only from those two values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks `in_keys` as a vector to sort |
| in_keys | input | N*W | N unsigned keys, lane i at bits i*W +: W |
| out_valid | output | 1 | Marks `out_keys` as a sorted vector |
| out_keys | output | N*W | Sorted keys, smallest in lane 0 |

## Verification
The hardest thing to provoke from the ports is a vector that drives every comparator of every column in both the exchange and the pass-through direction, while neighbouring columns hold unrelated vectors or discarded idle data. To reach it, the stimulus streams all 2^N vectors built from the keys 0 and 2^W-1 back to back. A network that sorts every two-valued input sorts every input, so this sweep covers every comparator decision. Pseudo-random vectors with narrow key ranges follow, to force many duplicate keys. These are interleaved with idle cycles that carry garbage keys, and with runs of all-equal, ascending and descending vectors.

// File: rtl/bsort_pkg.sv
// Package bsort_pkg
// Maps a pipeline column index onto the bitonic schedule. Columns are numbered
// from 0 at the input. Level p (block size 2^p) holds p columns, whose partner
// distances are 2^(p-1) down to 1.
// Assumes fewer than 17 levels, i.e. N <= 65536.
package bsort_pkg;

    // Number of register columns for a network of 2^lg lanes.
    function automatic int col_count(input int lg);
        return lg * (lg + 1) / 2;
    endfunction

    // log2 of the merge block size used by column s.
    function automatic int col_blk_log(input int s);
        int c;
        int r;
        c = 0;
        r = 1;
        for (int p = 1; p <= 16; p++) begin
            for (int q = p - 1; q >= 0; q--) begin
                if (c == s) r = p;
                c++;
            end
        end
        return r;
    endfunction

    // log2 of the partner distance used by column s.
    function automatic int col_dst_log(input int s);
        int c;
        int r;
        c = 0;
        r = 0;
        for (int p = 1; p <= 16; p++) begin
            for (int q = p - 1; q >= 0; q--) begin
                if (c == s) r = q;
                c++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/bsort_cmpx.sv
// Module bsort_cmpx
// Combinational compare-exchange on two keys. With ASC set, the smaller key
// goes to lo_k; otherwise the larger key goes to lo_k. Keys are swapped only
// when strictly out of order, so equal keys keep their lanes.
module bsort_cmpx #(
    parameter int W   = 8,
    parameter bit ASC = 1'b1
) (
    input  logic [W-1:0] a_k,
    input  logic [W-1:0] b_k,
    output logic [W-1:0] lo_k,
    output logic [W-1:0] hi_k
);

    logic swap;

    // Decide whether the pair is out of order for this direction.
    always_comb begin
        if (ASC) swap = (a_k > b_k);
        else     swap = (a_k < b_k);
    end

    // Route the pair according to the decision.
    always_comb begin
        lo_k = swap ? b_k : a_k;
        hi_k = swap ? a_k : b_k;
    end

endmodule

// File: rtl/bsort_column.sv
// Module bsort_column
// One registered comparator column. Lane i pairs with lane i + 2^DST_LOG
// whenever bit DST_LOG of i is clear. A pair sorts ascending when bit BLK_LOG
// of i is clear and descending otherwise. When BLK_LOG equals log2(N), every
// pair sorts ascending. Keys and valid advance one column per clock.
// Assumes N is a power of two and DST_LOG < BLK_LOG <= log2(N).
module bsort_column #(
    parameter int N       = 8,
    parameter int W       = 8,
    parameter int BLK_LOG = 1,
    parameter int DST_LOG = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         d_vld,
    input  logic [N*W-1:0] d_keys,
    output logic         q_vld,
    output logic [N*W-1:0] q_keys
);

    localparam int DST = 1 << DST_LOG;

    logic [N*W-1:0] nxt;

    // Build the compare-exchange elements of this column.
    for (genvar i = 0; i < N; i++) begin : g_lane
        if ((i & DST) == 0) begin : g_pair
            localparam bit UP = ((i >> BLK_LOG) & 1) == 0;
            bsort_cmpx #(.W(W), .ASC(UP)) cx_i (
                .a_k  (d_keys[i*W +: W]),
                .b_k  (d_keys[(i+DST)*W +: W]),
                .lo_k (nxt[i*W +: W]),
                .hi_k (nxt[(i+DST)*W +: W])
            );
        end
    end

    // Column register: clear on reset, otherwise capture the exchanged keys.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vld  <= 1'b0;
            q_keys <= '0;
        end else begin
            q_vld  <= d_vld;
            q_keys <= nxt;
        end
    end

endmodule

// File: rtl/bsort_pipe.sv
// Module bsort_pipe
// Top of the pipelined bitonic sorter. It chains log2(N)(log2(N)+1)/2
// registered columns, taking their schedule from bsort_pkg. One vector may
// enter per cycle. The valid bit travels with the keys, so latency is exactly
// the column count.
// Assumes N is a power of two and at least 2.
module bsort_pipe #(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [N*W-1:0] in_keys,
    output logic           out_valid,
    output logic [N*W-1:0] out_keys
);

    localparam int LG     = $clog2(N);
    localparam int STAGES = bsort_pkg::col_count(LG);

    logic [N*W-1:0] st_keys [STAGES+1];
    logic           st_vld  [STAGES+1];

    // Feed the first column from the ports.
    assign st_keys[0] = in_keys;
    assign st_vld[0]  = in_valid;

    // Instantiate one column per pipeline stage.
    for (genvar s = 0; s < STAGES; s++) begin : g_col
        bsort_column #(
            .N       (N),
            .W       (W),
            .BLK_LOG (bsort_pkg::col_blk_log(s)),
            .DST_LOG (bsort_pkg::col_dst_log(s))
        ) col_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .d_vld  (st_vld[s]),
            .d_keys (st_keys[s]),
            .q_vld  (st_vld[s+1]),
            .q_keys (st_keys[s+1])
        );
    end

    // Drive the outputs from the last column.
    assign out_valid = st_vld[STAGES];
    assign out_keys  = st_keys[STAGES];

endmodule

// File: rtl/bsort_chk.sv
// Module bsort_chk
// Property checker for bsort_pipe. It keeps its own delay lines of input
// valid and input key sums, and compares them against the outputs. It also
// checks the output ordering and the reset behaviour.
module bsort_chk #(
    parameter int N = 8,
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [N*W-1:0] in_keys,
    input logic           out_valid,
    input logic [N*W-1:0] out_keys
);

    localparam int LG     = $clog2(N);
    localparam int STAGES = LG * (LG + 1) / 2;
    localparam int SW     = W + LG;

    logic [SW-1:0] in_sum;
    logic [SW-1:0] out_sum;
    logic          ordered;
    logic          vld_sr [STAGES];
    logic [SW-1:0] sum_sr [STAGES];

    // Sum the input keys and the output keys.
    always_comb begin
        in_sum  = '0;
        out_sum = '0;
        for (int i = 0; i < N; i++) begin
            in_sum  = in_sum  + SW'(in_keys[i*W +: W]);
            out_sum = out_sum + SW'(out_keys[i*W +: W]);
        end
    end

    // Flag whether the output lanes are non-decreasing.
    always_comb begin
        ordered = 1'b1;
        for (int i = 0; i + 1 < N; i++)
            if (out_keys[i*W +: W] > out_keys[(i+1)*W +: W]) ordered = 1'b0;
    end

    // Delay lines for valid and key sum, one slot per column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                vld_sr[s] <= 1'b0;
                sum_sr[s] <= '0;
            end
        end else begin
            vld_sr[0] <= in_valid;
            sum_sr[0] <= in_sum;
            for (int s = 1; s < STAGES; s++) begin
                vld_sr[s] <= vld_sr[s-1];
                sum_sr[s] <= sum_sr[s-1];
            end
        end
    end

    // R1: output valid matches input valid after the column count.
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vld_sr[STAGES-1]);

    // R2: a valid output is in ascending order.
    p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ordered);

    // R3: key sum is preserved between input and output.
    p_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sum == sum_sr[STAGES-1]));

    // R5: a sampled reset clears valid and keys on the next cycle.
    p_reset_r5: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_keys == '0));

endmodule

bind bsort_pipe bsort_chk #(.N(N), .W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_keys   (in_keys),
    .out_valid (out_valid),
    .out_keys  (out_keys)
);

// File: tb/bsort_pipe_tb_top.sv
// Bench for bsort_pipe with N=8, W=8. Each vector is sorted in the bench and
// queued together with its entry cycle. The monitor compares every output
// against that queue.
module bsort_pipe_tb_top;

    localparam int N   = 8;
    localparam int W   = 8;
    localparam int LG  = 3;
    localparam int LAT = LG * (LG + 1) / 2;

    logic           clk;
    logic           rst_n;
    logic           in_valid;
    logic [N*W-1:0] in_keys;
    logic           out_valid;
    logic [N*W-1:0] out_keys;

    int checks;
    int failures;
    int cyc;
    int run_len;
    int max_run;
    bit done;
    bit mon_on;
    logic [31:0] seed;

    logic [N*W-1:0] exp_q [$];
    int             t_q   [$];
    string          tag_q [$];

    bsort_pipe #(.N(N), .W(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_keys   (in_keys),
        .out_valid (out_valid),
        .out_keys  (out_keys)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // Reference sort, written independently of the network.
    function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] v);
        int a [N];
        int t;
        logic [N*W-1:0] r;
        for (int i = 0; i < N; i++) a[i] = int'(v[i*W +: W]);
        for (int i = 0; i < N; i++)
            for (int j = 0; j + 1 < N - i; j++)
                if (a[j] > a[j+1]) begin
                    t = a[j]; a[j] = a[j+1]; a[j+1] = t;
                end
        for (int i = 0; i < N; i++) r[i*W +: W] = W'(a[i]);
        return r;
    endfunction

    function automatic logic [31:0] lcg(input logic [31:0] s);
        return s * 32'd1103515245 + 32'd12345;
    endfunction

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [N*W-1:0] v, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_keys  = v;
        exp_q.push_back(ref_sort(v));
        t_q.push_back(cyc);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            seed = lcg(seed);
            in_valid = 1'b0;
            in_keys  = {seed, ~seed};
        end
    endtask

    // Cycle counter and watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            report();
            $finish;
        end
    end

    // Output monitor: ordering and permutation (R2, R3), latency (R1), no
    // spurious valid (R8), run length (R4).
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                run_len++;
                if (run_len > max_run) max_run = run_len;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected out_valid", out_keys, '0);
                end else begin
                    automatic logic [N*W-1:0] e = exp_q.pop_front();
                    automatic int t0 = t_q.pop_front();
                    automatic string tg = tag_q.pop_front();
                    chk(out_keys == e, tg, "sorted keys", out_keys, e);
                    chk((cyc - t0) == LAT, "R1", "latency",
                        (N*W)'(cyc - t0), (N*W)'(LAT));
                end
            end else begin
                run_len = 0;
            end
        end
    end

    initial begin
        checks = 0; failures = 0; cyc = 0; run_len = 0; max_run = 0;
        done = 1'b0; mon_on = 1'b0; seed = 32'h1234_5678;
        rst_n = 1'b0;
        in_valid = 1'b1;
        in_keys = 64'hDEAD_BEEF_0BAD_F00D;
        // R5: reset holds outputs clear even with valid input present.
        repeat (3) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R5", "valid in reset", {63'd0, out_valid}, '0);
            chk(out_keys == '0, "R5", "keys in reset", out_keys, '0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;
        mon_on = 1'b1;
        // R8: idle garbage creates no output.
        idle(LAT + 4);
        chk(exp_q.size() == 0 && out_valid == 1'b0, "R8", "idle output",
            {63'd0, out_valid}, '0);

        // R9 and R4: every two-valued vector, back to back.
        for (int m = 0; m < (1 << N); m++) begin
            automatic logic [N*W-1:0] v;
            for (int i = 0; i < N; i++) v[i*W +: W] = m[i] ? {W{1'b1}} : '0;
            send(v, "R9");
        end
        idle(LAT + 2);
        chk(max_run >= (1 << N), "R4", "back-to-back run",
            (N*W)'(max_run), (N*W)'(1 << N));

        // R6: all-equal vectors for every key value.
        for (int k = 0; k < (1 << W); k++)
            send({N{W'(k)}}, "R6");
        // R7: ascending and descending inputs.
        for (int b = 0; b < 32; b++) begin
            automatic logic [N*W-1:0] up;
            automatic logic [N*W-1:0] dn;
            for (int i = 0; i < N; i++) begin
                up[i*W +: W] = W'(b + 7 * i);
                dn[i*W +: W] = W'(200 - b - 3 * i);
            end
            send(up, "R7");
            send(dn, "R7");
        end

        // R2, R3, R8: random vectors, narrow key ranges, random gaps.
        for (int n = 0; n < 3000; n++) begin
            automatic logic [N*W-1:0] v;
            for (int i = 0; i < N; i++) begin
                seed = lcg(seed);
                case (n % 3)
                    0: v[i*W +: W] = seed[23:16];
                    1: v[i*W +: W] = {5'd0, seed[18:16]};
                    default: v[i*W +: W] = {7'd0, seed[16]} + 8'd127;
                endcase
            end
            send(v, (n % 2 == 0) ? "R2" : "R3");
            seed = lcg(seed);
            if (seed[27:25] == 3'd0) idle(int'(seed[30:28]) + 1);
        end

        idle(LAT + 4);
        chk(exp_q.size() == 0, "R1", "all vectors emitted",
            (N*W)'(exp_q.size()), '0);
        done = 1'b1;
        report();
        $finish;
    end

endmodule